// File: doc/BRIEF.md
# Flash Transfer Splitter

This block turns one flash request (an operation, a start offset and a byte total) into a series of sequencer cycles. Each cycle moves no more than one data FIFO's worth of bytes, and it never runs past a program page boundary when it starts partway into a page. For each cycle the block presents a control word to a hardware sequencer. The word holds the cycle code, the byte count minus one, the flash address and a clear strobe for the stale status flags. The block pulses go, then watches the sequencer's cycle-error, access-error and done flags. From these it advances, stops with an error, or times out.

A host pulses `req_start` with the request fields and waits for `xfer_done`, which carries a result code. While a request is running, `seq_buf_idx` tells the data path which byte of the caller's buffer belongs to the cycle in flight.

Top module: `flash_xfer_splitter`

## Requirements
- R1: Each cycle's length is the smallest of three values: the bytes remaining, the FIFO size (64), and the distance to the next page boundary. The page-boundary limit applies only when the offset does not sit on a page boundary. An aligned offset is limited only by the remaining bytes and the FIFO size.
- R2: A `page_cfg` of 0 selects a 256-byte page. A non-zero `page_cfg` is taken as the page size and must be a power of two.
- R3: Every cycle asserts `seq_go` for exactly one clock. In that same clock the block shows `seq_clr`=1, `seq_addr` equal to the current offset, and `seq_count` equal to the cycle length minus one.
- R4: After each done flag, the offset and `seq_buf_idx` both advance by the cycle length. `seq_buf_idx` starts at 0. The request ends with result 0 (ok) once no bytes remain. `xfer_done` is a single-clock pulse.
- R5: While waiting, the flags are judged in priority order. Cycle error ends the request with result 1, and wins over the other two. Access error ends it with result 2 and wins over done. No further cycle is issued after an error.
- R6: An erase request (op 5) issues exactly one cycle at the given offset with `seq_count`=0, whatever `req_len` says, and ends with result 0.
- R7: If none of the three flags appears within TIMEOUT_CYC clocks after go, the request ends with result 3. The count restarts for every cycle.
- R8: `req_op` selects the cycle code on `seq_cycle` as follows:
  - op 0 (read) gives code 0
  - op 1 (write) gives code 2
  - op 2 (read ID) gives code 6
  - op 3 (read status) gives code 8
  - op 4 (write status) gives code 7
  - op 5 (4 KB erase) gives code 3
- R9: Op 6 (write enable) and op 7 (write disable) complete with result 0 and issue no cycle. So does any non-erase request with `req_len`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Starts a request when idle |
| req_op | input | 3 | Operation code (R8, R9) |
| req_offset | input | ADDR_W | Start flash offset |
| req_len | input | LEN_W | Total bytes |
| page_cfg | input | PAGE_W | Page size, 0 means 256 |
| busy | output | 1 | Request in progress |
| xfer_done | output | 1 | One-clock completion pulse |
| xfer_result | output | 2 | 0 ok, 1 cycle error, 2 access error, 3 timeout |
| seq_go | output | 1 | Start one sequencer cycle |
| seq_clr | output | 1 | Write-one clear of the three flags |
| seq_cycle | output | 4 | Cycle code |
| seq_count | output | CNT_W | Cycle byte count minus one |
| seq_addr | output | ADDR_W | Cycle flash address |
| seq_buf_idx | output | LEN_W | Buffer index of the cycle's first byte |
| seq_done | input | 1 | Sequencer done flag |
| seq_cerr | input | 1 | Sequencer cycle error flag |
| seq_aerr | input | 1 | Sequencer access error flag |

## Verification
The splitting is tried with several request shapes, and each shape separates a different limit:
- an aligned long read, which splits purely on FIFO size;
- offsets just below a 256-byte boundary, which exercise the short first piece;
- a small programmed page, both unaligned (where the page limit bites) and aligned (where it must not);
- a default page selected by writing 0.

Erase, the two enable-type ops, and zero-length reads show how a cycle count of one or zero differs from normal splitting. Sequencer responses that raise several flags together pin down the flag priority, an error on a later cycle shows that no cycle follows it, and a silent sequencer shows the timeout.

// File: rtl/flash_xfer_pkg.sv
package flash_xfer_pkg;

   typedef enum logic [2:0] {
      OP_READ    = 3'd0,
      OP_WRITE   = 3'd1,
      OP_RDID    = 3'd2,
      OP_RDSR    = 3'd3,
      OP_WRSR    = 3'd4,
      OP_ERASE4K = 3'd5,
      OP_WREN    = 3'd6,
      OP_WRDIS   = 3'd7
   } xfer_op_e;

   typedef enum logic [1:0] {
      RES_OK         = 2'd0,
      RES_CYCLE_ERR  = 2'd1,
      RES_ACCESS_ERR = 2'd2,
      RES_TIMEOUT    = 2'd3
   } xfer_res_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } xfer_st_e;

   // Sequencer cycle code for each request operation
   function automatic logic [3:0] cycle_code(input xfer_op_e op);
      case (op)
         OP_READ:    return 4'h0;
         OP_WRITE:   return 4'h2;
         OP_ERASE4K: return 4'h3;
         OP_RDID:    return 4'h6;
         OP_WRSR:    return 4'h7;
         OP_RDSR:    return 4'h8;
         default:    return 4'hF;
      endcase
   endfunction

endpackage

// File: rtl/fxs_chunk_calc.sv
module fxs_chunk_calc #(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 16,
   parameter int PAGE_W     = 16,
   parameter int FIFO_BYTES = 64,
   parameter int DEF_PAGE   = 256
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  remain,
   input  logic [PAGE_W-1:0] page_cfg,
   output logic [LEN_W-1:0]  chunk_len
);
   localparam int W = ((LEN_W > PAGE_W) ? LEN_W : PAGE_W) + 1;

   generate
      if (ADDR_W < PAGE_W) begin : g_bad_addr
         $error("fxs_chunk_calc: ADDR_W must be at least PAGE_W");
      end
      if (DEF_PAGE >= (1 << PAGE_W) || DEF_PAGE < 1) begin : g_bad_page
         $error("fxs_chunk_calc: DEF_PAGE does not fit PAGE_W");
      end
   endgenerate

   logic [PAGE_W-1:0] page_eff;
   logic [PAGE_W-1:0] in_page;
   logic [W-1:0]      to_edge;
   logic [W-1:0]      lim_a;

   always_comb begin
      page_eff  = (page_cfg == '0) ? PAGE_W'(DEF_PAGE) : page_cfg;
      in_page   = offset[PAGE_W-1:0] & (page_eff - 1'b1);
      to_edge   = W'(page_eff) - W'(in_page);
      lim_a     = (W'(remain) < W'(FIFO_BYTES)) ? W'(remain) : W'(FIFO_BYTES);
      if ((in_page != '0) && (to_edge < lim_a))
         chunk_len = LEN_W'(to_edge);
      else
         chunk_len = LEN_W'(lim_a);
   end

endmodule

// File: rtl/fxs_timeout.sv
module fxs_timeout #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("fxs_timeout: LIMIT must be positive");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (run && !expired)
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == TW'(LIMIT - 1));

endmodule

// File: rtl/flash_xfer_splitter.sv
module flash_xfer_splitter
   import flash_xfer_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int LEN_W       = 16,
   parameter int PAGE_W      = 16,
   parameter int FIFO_BYTES  = 64,
   parameter int DEF_PAGE    = 256,
   parameter int TIMEOUT_CYC = 1000,
   localparam int CNT_W      = $clog2(FIFO_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [PAGE_W-1:0] page_cfg,
   output logic              busy,
   output logic              xfer_done,
   output logic [1:0]        xfer_result,
   output logic              seq_go,
   output logic              seq_clr,
   output logic [3:0]        seq_cycle,
   output logic [CNT_W-1:0]  seq_count,
   output logic [ADDR_W-1:0] seq_addr,
   output logic [LEN_W-1:0]  seq_buf_idx,
   input  logic              seq_done,
   input  logic              seq_cerr,
   input  logic              seq_aerr
);

   generate
      if (FIFO_BYTES < 2 || (FIFO_BYTES & (FIFO_BYTES - 1)) != 0) begin : g_bad_fifo
         $error("flash_xfer_splitter: FIFO_BYTES must be a power of two >= 2");
      end
      if ((1 << LEN_W) <= FIFO_BYTES) begin : g_bad_len
         $error("flash_xfer_splitter: LEN_W too narrow for FIFO_BYTES");
      end
   endgenerate

   xfer_st_e          state;
   xfer_op_e          op_q;
   logic [ADDR_W-1:0] off_q;
   logic [LEN_W-1:0]  rem_q;
   logic [LEN_W-1:0]  idx_q;
   logic [PAGE_W-1:0] page_q;
   logic [1:0]        res_q;
   logic              done_q;
   logic [LEN_W-1:0]  chunk;
   logic              is_erase;
   logic              no_cycle;
   logic              last_piece;
   logic              tmo;

   fxs_chunk_calc #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
      .FIFO_BYTES(FIFO_BYTES), .DEF_PAGE(DEF_PAGE)
   ) u_calc (
      .offset(off_q), .remain(rem_q), .page_cfg(page_q), .chunk_len(chunk)
   );

   fxs_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clear(seq_go),
      .run(state == ST_WAIT), .expired(tmo)
   );

   always_comb begin
      is_erase   = (op_q == OP_ERASE4K);
      no_cycle   = (op_q == OP_WREN) || (op_q == OP_WRDIS) ||
                   ((rem_q == '0) && !is_erase);
      last_piece = is_erase || (rem_q == chunk);
      seq_go     = (state == ST_ISSUE) && !no_cycle;
      seq_clr    = seq_go;
      seq_cycle  = cycle_code(op_q);
      seq_count  = is_erase ? '0 : CNT_W'(chunk - 1'b1);
      seq_addr   = off_q;
   end

   assign seq_buf_idx = idx_q;
   assign busy        = (state != ST_IDLE);
   assign xfer_done   = done_q;
   assign xfer_result = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= OP_READ;
         off_q  <= '0;
         rem_q  <= '0;
         idx_q  <= '0;
         page_q <= '0;
         res_q  <= RES_OK;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_start) begin
                  op_q   <= xfer_op_e'(req_op);
                  off_q  <= req_offset;
                  rem_q  <= req_len;
                  page_q <= page_cfg;
                  idx_q  <= '0;
                  state  <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (no_cycle) begin
                  res_q  <= RES_OK;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (seq_cerr) begin
                  res_q  <= RES_CYCLE_ERR;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (seq_aerr) begin
                  res_q  <= RES_ACCESS_ERR;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (seq_done) begin
                  off_q <= off_q + ADDR_W'(chunk);
                  rem_q <= is_erase ? '0 : rem_q - chunk;
                  idx_q <= idx_q + chunk;
                  if (last_piece) begin
                     res_q  <= RES_OK;
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state  <= ST_ISSUE;
                  end
               end else if (tmo) begin
                  res_q  <= RES_TIMEOUT;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fxs_checker.sv
module fxs_checker
   import flash_xfer_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int PAGE_W      = 16,
   parameter int CNT_W       = 6,
   parameter int DEF_PAGE    = 256,
   parameter int TIMEOUT_CYC = 1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        st,
   input logic [PAGE_W-1:0] page_now,
   input logic              seq_go,
   input logic [3:0]        seq_cycle,
   input logic [CNT_W-1:0]  seq_count,
   input logic [ADDR_W-1:0] seq_addr,
   input logic              seq_done,
   input logic              seq_cerr,
   input logic              seq_aerr,
   input logic              xfer_done,
   input logic [1:0]        xfer_result
);
   logic [31:0] pe;
   logic [31:0] ip;
   logic [31:0] wait_cnt;

   always_comb begin
      pe = (page_now == '0) ? 32'(DEF_PAGE) : 32'(page_now);
      ip = 32'(seq_addr) % pe;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_cnt <= '0;
      else if (seq_go)
         wait_cnt <= '0;
      else if (st == ST_WAIT)
         wait_cnt <= wait_cnt + 1;
   end

   p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_go |=> !seq_go);

   p_page_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_go && seq_cycle != 4'h3 && ip != 0) |-> (ip + 32'(seq_count) + 1 <= pe));

   p_erase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_go && seq_cycle == 4'h3) |-> (seq_count == '0));

   p_cerr_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && seq_cerr) |=> (xfer_done && xfer_result == 2'd1));

   p_aerr_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !seq_cerr && seq_aerr) |=> (xfer_done && xfer_result == 2'd2));

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (wait_cnt < 32'(TIMEOUT_CYC)));

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !seq_cerr && !seq_aerr && seq_done) |=> !xfer_done || xfer_result == 2'd0);

endmodule

bind flash_xfer_splitter fxs_checker #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
   .DEF_PAGE(DEF_PAGE), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .st(state), .page_now(page_q),
   .seq_go(seq_go), .seq_cycle(seq_cycle), .seq_count(seq_count),
   .seq_addr(seq_addr), .seq_done(seq_done), .seq_cerr(seq_cerr),
   .seq_aerr(seq_aerr), .xfer_done(xfer_done), .xfer_result(xfer_result)
);

// File: tb/flash_xfer_splitter_bench.sv
`timescale 1ns/1ps
module flash_xfer_splitter_bench;
   localparam int ADDR_W = 24;
   localparam int LEN_W  = 16;
   localparam int PAGE_W = 16;
   localparam int CNT_W  = 6;
   localparam int TMO    = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_start = 1'b0;
   logic [2:0]        req_op = '0;
   logic [ADDR_W-1:0] req_offset = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic [PAGE_W-1:0] page_cfg = '0;
   logic              busy, xfer_done, seq_go, seq_clr;
   logic [1:0]        xfer_result;
   logic [3:0]        seq_cycle;
   logic [CNT_W-1:0]  seq_count;
   logic [ADDR_W-1:0] seq_addr;
   logic [LEN_W-1:0]  seq_buf_idx;
   logic              seq_done = 1'b0, seq_cerr = 1'b0, seq_aerr = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   flash_xfer_splitter #(.TIMEOUT_CYC(TMO)) u_flash_xfer_splitter (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
      .req_offset(req_offset), .req_len(req_len), .page_cfg(page_cfg),
      .busy(busy), .xfer_done(xfer_done), .xfer_result(xfer_result),
      .seq_go(seq_go), .seq_clr(seq_clr), .seq_cycle(seq_cycle),
      .seq_count(seq_count), .seq_addr(seq_addr), .seq_buf_idx(seq_buf_idx),
      .seq_done(seq_done), .seq_cerr(seq_cerr), .seq_aerr(seq_aerr)
   );

   // Sequencer model: response kind 0 done, 1 all flags, 2 access+done, 3 silent
   int resp_kind = 0;
   int err_at = 0;
   int ngo = 0;
   int pend = 0;
   int cd = 0;
   int log_addr [16];
   int log_cnt  [16];
   int log_cyc  [16];
   int log_clr  [16];
   int log_idx  [16];

   always @(negedge clk) begin
      seq_done <= 1'b0; seq_cerr <= 1'b0; seq_aerr <= 1'b0;
      if (pend != 0) begin
         if (cd == 0) begin
            pend = 0;
            if (ngo - 1 != err_at || resp_kind == 0) seq_done <= 1'b1;
            else if (resp_kind == 1) begin
               seq_done <= 1'b1; seq_cerr <= 1'b1; seq_aerr <= 1'b1;
            end else if (resp_kind == 2) begin
               seq_done <= 1'b1; seq_aerr <= 1'b1;
            end
         end else cd = cd - 1;
      end
      if (seq_go) begin
         if (ngo < 16) begin
            log_addr[ngo] = int'(seq_addr);
            log_cnt[ngo]  = int'(seq_count);
            log_cyc[ngo]  = int'(seq_cycle);
            log_clr[ngo]  = int'(seq_clr);
            log_idx[ngo]  = int'(seq_buf_idx);
         end
         ngo = ngo + 1;
         pend = 1; cd = 2;
      end
   end

   function automatic int exp_code(int op); // R8
      case (op)
         0: return 0; 1: return 2; 2: return 6;
         3: return 8; 4: return 7; 5: return 3;
         default: return 15;
      endcase
   endfunction

   function automatic int exp_piece(int off, int rem, int pg); // R1, R2
      int p, ip, c;
      p = (pg == 0) ? 256 : pg;
      c = (rem < 64) ? rem : 64;
      ip = off % p;
      if (ip != 0 && (p - ip) < c) c = p - ip;
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run_req(input int op, input int off, input int len, input int pg,
                          input int kind, input int eat, input int exp_res, input string tag);
      int waited, n_exp, o, r, ix, c, bad;
      ngo = 0; resp_kind = kind; err_at = eat;
      @(negedge clk);
      req_op = 3'(op); req_offset = ADDR_W'(off); req_len = LEN_W'(len);
      page_cfg = PAGE_W'(pg); req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      waited = 0;
      while (!xfer_done && waited < 3000) begin
         @(negedge clk); waited++;
      end
      check(waited < 3000, {tag, " completes"}, waited, 3000);
      check(int'(xfer_result) == exp_res, {tag, " result"}, int'(xfer_result), exp_res);
      // expected cycle list
      o = off; r = len; ix = 0; n_exp = 0; bad = 0;
      if (op == 6 || op == 7) n_exp = 0;
      else if (op == 5) begin
         n_exp = 1;
         if (ngo >= 1 && (log_addr[0] != off || log_cnt[0] != 0 || log_cyc[0] != 3 || log_clr[0] != 1))
            bad = 1;
      end else begin
         while (r > 0) begin
            c = exp_piece(o, r, pg);
            if (n_exp < ngo && n_exp < 16) begin
               if (log_addr[n_exp] != o || log_cnt[n_exp] != c - 1 || log_idx[n_exp] != ix ||
                   log_cyc[n_exp] != exp_code(op) || log_clr[n_exp] != 1) bad = 1;
            end
            n_exp++;
            if (kind != 0 && n_exp - 1 == eat) break;
            o += c; r -= c; ix += c;
         end
      end
      check(ngo == n_exp, {tag, " cycle count"}, ngo, n_exp);
      check(bad == 0, {tag, " cycle fields"}, bad, 0);
   endtask

   typedef struct packed {
      logic [2:0]  op;
      logic [23:0] off;
      logic [15:0] len;
      logic [15:0] pg;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 24'h000000, 16'd200, 16'd0},   // R1 FIFO split, R2 default page
      '{3'd1, 24'h0000F0, 16'd100, 16'd0},   // R1 short first piece
      '{3'd1, 24'h000010, 16'd40,  16'd32},  // R2 programmed page
      '{3'd0, 24'h000020, 16'd70,  16'd16},  // R1 aligned: no page limit
      '{3'd5, 24'h001000, 16'd500, 16'd0},   // R6 erase
      '{3'd2, 24'h000000, 16'd3,   16'd0},   // R8 read id
      '{3'd6, 24'h000000, 16'd0,   16'd0},   // R9 write enable
      '{3'd7, 24'h000000, 16'd8,   16'd0},   // R9 write disable
      '{3'd0, 24'h000400, 16'd0,   16'd0},   // R9 zero length
      '{3'd1, 24'h0000FF, 16'd5,   16'd256}, // R1 one byte to edge
      '{3'd4, 24'h000000, 16'd1,   16'd0}    // R8 write status
   };

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && xfer_done == 0 && seq_go == 0, "reset R4", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(seq_buf_idx == '0, "reset index R4", int'(seq_buf_idx), 0);

      for (int i = 0; i < NV; i++)
         run_req(int'(VECS[i].op), int'(VECS[i].off), int'(VECS[i].len),
                 int'(VECS[i].pg), 0, 0, 0, $sformatf("R1/R4 vec%0d", i));

      run_req(3, 0, 1, 0, 0, 0, 0, "R8 read status");
      run_req(0, 'h10, 150, 0, 1, 0, 1, "R5 all flags");
      run_req(1, 'h00, 150, 0, 2, 1, 2, "R5 access on 2nd");
      run_req(0, 'h00, 150, 0, 1, 2, 1, "R5 cycle err on 3rd");
      run_req(0, 'h00, 150, 0, 3, 0, 3, "R7 timeout");
      run_req(0, 'h00, 150, 0, 3, 1, 3, "R7 timeout 2nd piece");
      run_req(0, 'h08, 64, 8, 0, 0, 0, "R3 tiny page");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule